// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves one control-transfer operation per request. Each request carries an operation code, the address of the following instruction, the operand fields taken from the instruction, the accumulator, the 16-bit data pointer, the carry flag, one selected bit and two compare operands. From these the unit decides whether the branch is taken and computes the 16-bit destination. It also produces the side effects that some conditions have: a new carry from a compare, a decremented loop counter, and a strobe that clears the tested bit.

Results are registered. They appear one clock after the request together with a result-valid flag. Instruction fetch, the stack and the register file sit outside the unit. The surrounding core applies the target, the carry, the decremented value and the bit-clear strobe.

Top module: `brtc_unit`

## Requirements
- R1: A request sampled on a rising edge with `req_vld` high gives `res_vld` high after that edge with all results for it. In any cycle after an edge where `req_vld` was low, `res_vld`, `taken` and `bit_clr` are low.
- R2: Relative forms (codes 0 to 9) target `next_pc` plus `rel_off` read as a signed 8-bit value, modulo 2^16. The unconditional short jump (code 0) is always taken.
- R3: Page-local jump (code 10) and call (code 11) are always taken. Their target keeps bits 15:11 of `next_pc` and takes bits 10:0 from `abs_addr`.
- R4: Long jump (code 12) and call (code 13) are always taken with target `long_addr`. The indirect jump (code 14) is always taken with target `dptr + acc` modulo 2^16.
- R5: Code 1 is taken when `acc` is zero and code 2 when it is nonzero. Code 3 is taken when `cy_in` is 1 and code 4 when it is 0.
- R6: Code 5 is taken when `bit_in` is 1 and code 6 when it is 0. Code 7 is taken when `bit_in` is 1, and `bit_clr` is high exactly when code 7 is taken. `bit_clr` is low for every other code.
- R7: The compare jump (code 8) is taken when `cmp_a` differs from `cmp_b`, and `cy_out` is 1 exactly when `cmp_a < cmp_b` unsigned. For every other code `cy_out` equals `cy_in`.
- R8: The decrement jump (code 9) gives `dec_val = cmp_a - 1` modulo 256, so 0x00 becomes 0xFF. It is taken when that new value is nonzero. For every other code `dec_val` equals `cmp_a`.
- R9: Code 15 is a no-op: not taken, target equal to `next_pc`, no bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| op_type | input | 4 | Operation code (see R2 to R9) |
| next_pc | input | 16 | Address of the following instruction |
| rel_off | input | 8 | Signed relative offset |
| abs_addr | input | 11 | Page-local address field |
| long_addr | input | 16 | Full address field |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Selected bit value |
| cmp_a | input | 8 | First compare / loop counter operand |
| cmp_b | input | 8 | Second compare operand |
| res_vld | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| target | output | 16 | Destination address |
| cy_out | output | 1 | Carry after the operation |
| dec_val | output | 8 | Decremented (or passed) operand |
| bit_clr | output | 1 | Clear-the-tested-bit strobe |

## Verification
The only state is the result register, so a fault in it shows at the ports exactly one cycle after the request that caused it. There is no hidden history that could delay or mask an error. A wrong condition decode shows as a flipped `taken` or a stray `bit_clr`. A wrong sign extension or page split shows in the upper target bits only for negative offsets or pages other than zero, which the directed cases exercise at the wrap points.

// File: rtl/brtc_pkg.sv
package brtc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 11;
    localparam int OFF_W  = 8;
    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        BR_SHORT = 4'd0,  BR_JZ    = 4'd1,  BR_JNZ   = 4'd2,  BR_JC  = 4'd3,
        BR_JNC   = 4'd4,  BR_JB    = 4'd5,  BR_JNB   = 4'd6,  BR_JBC = 4'd7,
        BR_CMPNE = 4'd8,  BR_DECNZ = 4'd9,  BR_PJMP  = 4'd10, BR_PCALL = 4'd11,
        BR_LJMP  = 4'd12, BR_LCALL = 4'd13, BR_INDIR = 4'd14, BR_NOP = 4'd15
    } br_kind_e;

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              cy;
        logic [DATA_W-1:0] dec;
        logic              bclr;
    } br_res_t;
endpackage

// File: rtl/brtc_target.sv
module brtc_target
    import brtc_pkg::*;
(
    input  br_kind_e          kind,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [PAGE_W-1:0] abs_addr,
    input  logic [ADDR_W-1:0] long_addr,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam int ZPAD  = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] page_tgt;
    logic [ADDR_W-1:0] ind_tgt;

    always_comb begin
        rel_tgt  = next_pc + {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
        page_tgt = {next_pc[ADDR_W-1:PAGE_W], abs_addr};
        ind_tgt  = dptr + {{ZPAD{1'b0}}, acc};
        unique case (kind)
            BR_PJMP, BR_PCALL: target = page_tgt;
            BR_LJMP, BR_LCALL: target = long_addr;
            BR_INDIR:          target = ind_tgt;
            BR_NOP:            target = next_pc;
            default:           target = rel_tgt;
        endcase
    end
endmodule

// File: rtl/brtc_cond.sv
module brtc_cond
    import brtc_pkg::*;
(
    input  br_kind_e          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic              taken,
    output logic              cy_out,
    output logic [DATA_W-1:0] dec_val,
    output logic              bit_clr
);
    logic              acc_zero;
    logic [DATA_W-1:0] dec_raw;

    always_comb begin
        acc_zero = (acc == '0);
        dec_raw  = cmp_a - DATA_W'(1);
        cy_out   = cy_in;
        dec_val  = cmp_a;
        bit_clr  = 1'b0;
        taken    = 1'b0;
        unique case (kind)
            BR_JZ:    taken = acc_zero;
            BR_JNZ:   taken = !acc_zero;
            BR_JC:    taken = cy_in;
            BR_JNC:   taken = !cy_in;
            BR_JB:    taken = bit_in;
            BR_JNB:   taken = !bit_in;
            BR_JBC: begin
                taken   = bit_in;
                bit_clr = bit_in;
            end
            BR_CMPNE: begin
                taken  = (cmp_a != cmp_b);
                cy_out = (cmp_a < cmp_b);
            end
            BR_DECNZ: begin
                dec_val = dec_raw;
                taken   = (dec_raw != '0);
            end
            BR_NOP:   taken = 1'b0;
            default:  taken = 1'b1;
        endcase
    end
endmodule

// File: rtl/brtc_unit.sv
module brtc_unit
    import brtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [KIND_W-1:0] op_type,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [PAGE_W-1:0] abs_addr,
    input  logic [ADDR_W-1:0] long_addr,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic              res_vld,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              cy_out,
    output logic [DATA_W-1:0] dec_val,
    output logic              bit_clr
);
    br_kind_e          kind;
    logic [ADDR_W-1:0] tgt_c;
    logic              tkn_c, cy_c, bclr_c;
    logic [DATA_W-1:0] dec_c;
    br_res_t           res_d, res_q;

    assign kind = br_kind_e'(op_type);

    brtc_target u_target (
        .kind(kind), .next_pc(next_pc), .rel_off(rel_off), .abs_addr(abs_addr),
        .long_addr(long_addr), .acc(acc), .dptr(dptr), .target(tgt_c)
    );

    brtc_cond u_cond (
        .kind(kind), .acc(acc), .cy_in(cy_in), .bit_in(bit_in),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .taken(tkn_c), .cy_out(cy_c),
        .dec_val(dec_c), .bit_clr(bclr_c)
    );

    always_comb begin
        res_d       = res_q;
        res_d.vld   = req_vld;
        res_d.taken = 1'b0;
        res_d.bclr  = 1'b0;
        if (req_vld) begin
            res_d.taken  = tkn_c;
            res_d.target = tgt_c;
            res_d.cy     = cy_c;
            res_d.dec    = dec_c;
            res_d.bclr   = bclr_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_vld = res_q.vld;
    assign taken   = res_q.taken;
    assign target  = res_q.target;
    assign cy_out  = res_q.cy;
    assign dec_val = res_q.dec;
    assign bit_clr = res_q.bclr;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (!taken && !bit_clr)); // R1
    AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_type) <= 4'd9) |->
        target == $past(next_pc) + {{(ADDR_W-OFF_W){$past(rel_off[OFF_W-1])}}, $past(rel_off)}); // R2
    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && ($past(op_type) == 4'd10 || $past(op_type) == 4'd11)) |->
        (target[ADDR_W-1:PAGE_W] == $past(next_pc[ADDR_W-1:PAGE_W]) && taken)); // R3
    AST_BCLR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clr |-> (taken && $past(op_type) == 4'd7)); // R6
    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_type) == 4'd8) |-> (cy_out == ($past(cmp_a) < $past(cmp_b)))); // R7
    AST_DEC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_type) == 4'd9) |-> (taken == (dec_val != '0))); // R8
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(op_type) == 4'd15) |-> (!taken && target == $past(next_pc))); // R9
endmodule

// File: tb/brtc_unit_tb.sv
module brtc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [3:0]  op_type = '0;
    logic [15:0] next_pc = '0, long_addr = '0, dptr = '0;
    logic [7:0]  rel_off = '0, acc = '0, cmp_a = '0, cmp_b = '0;
    logic [10:0] abs_addr = '0;
    logic        cy_in = 1'b0, bit_in = 1'b0;
    logic        res_vld, taken, cy_out, bit_clr;
    logic [15:0] target;
    logic [7:0]  dec_val;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    brtc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .op_type(op_type),
        .next_pc(next_pc), .rel_off(rel_off), .abs_addr(abs_addr),
        .long_addr(long_addr), .acc(acc), .dptr(dptr), .cy_in(cy_in),
        .bit_in(bit_in), .cmp_a(cmp_a), .cmp_b(cmp_b), .res_vld(res_vld),
        .taken(taken), .target(target), .cy_out(cy_out), .dec_val(dec_val),
        .bit_clr(bit_clr)
    );

    function automatic string tag_of(input logic [3:0] k);
        if (k == 0)                 return "R2";
        else if (k <= 4)            return "R5";
        else if (k <= 7)            return "R6";
        else if (k == 8)            return "R7";
        else if (k == 9)            return "R8";
        else if (k <= 11)           return "R3";
        else if (k <= 14)           return "R4";
        return "R9";
    endfunction

    function automatic logic exp_taken(input logic [3:0] k);
        case (k)
            4'd1: return acc == 0;
            4'd2: return acc != 0;
            4'd3: return cy_in;
            4'd4: return !cy_in;
            4'd5, 4'd7: return bit_in;
            4'd6: return !bit_in;
            4'd8: return cmp_a != cmp_b;
            4'd9: return cmp_a != 8'd1;
            4'd15: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] exp_target(input logic [3:0] k);
        int signed off;
        off = int'($signed(rel_off));
        if (k <= 9)                 return 16'(int'(next_pc) + off);
        if (k == 10 || k == 11)     return {next_pc[15:11], abs_addr};
        if (k == 12 || k == 13)     return long_addr;
        if (k == 14)                return 16'(int'(dptr) + int'(acc));
        return next_pc;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_one;
        logic [3:0]  k;
        logic        et, ec, eb;
        logic [15:0] eg;
        logic [7:0]  ed;
        string       t;
        k  = op_type;
        t  = tag_of(k);
        et = exp_taken(k);
        eg = exp_target(k);
        ec = (k == 4'd8) ? (cmp_a < cmp_b) : cy_in;
        ed = (k == 4'd9) ? cmp_a - 8'd1 : cmp_a;
        eb = (k == 4'd7) && bit_in;
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
        chk("R1", "res_vld", int'(res_vld), 1);
        chk(t, "taken", int'(taken), int'(et));
        chk((k <= 9) ? "R2" : t, "target", int'(target), int'(eg));
        chk("R7", "cy_out", int'(cy_out), int'(ec));
        chk("R8", "dec_val", int'(dec_val), int'(ed));
        chk("R6", "bit_clr", int'(bit_clr), int'(eb));
    endtask

    task automatic randomize_inputs;
        op_type   = 4'($urandom);
        next_pc   = 16'($urandom);
        rel_off   = 8'($urandom);
        abs_addr  = 11'($urandom);
        long_addr = 16'($urandom);
        acc       = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
        dptr      = 16'($urandom);
        cy_in     = 1'($urandom);
        bit_in    = 1'($urandom);
        cmp_a     = ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'($urandom);
        cmp_b     = ($urandom % 3 == 0) ? cmp_a : 8'($urandom);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1b2c3d4e));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset res_vld", int'(res_vld), 0);
        chk("R1", "reset taken", int'(taken), 0);
        chk("R1", "reset bit_clr", int'(bit_clr), 0);

        // R2 wrap forward past 0xFFFF and largest backward offset
        op_type = 4'd0; next_pc = 16'hFFF0; rel_off = 8'h7F; run_one();
        op_type = 4'd0; next_pc = 16'h0010; rel_off = 8'h80; run_one();
        // R3 page kept from next_pc
        op_type = 4'd11; next_pc = 16'hF800; abs_addr = 11'h7FF; run_one();
        // R4 indirect wraps
        op_type = 4'd14; dptr = 16'hFFFF; acc = 8'h02; run_one();
        // R8 decrement from 0x00 and from 0x01
        op_type = 4'd9; cmp_a = 8'h00; rel_off = 8'hFE; run_one();
        op_type = 4'd9; cmp_a = 8'h01; run_one();
        // R7 equal operands and a < b
        op_type = 4'd8; cmp_a = 8'h40; cmp_b = 8'h40; cy_in = 1'b1; run_one();
        op_type = 4'd8; cmp_a = 8'h00; cmp_b = 8'hFF; cy_in = 1'b0; run_one();
        // R6 test-and-clear with bit set and clear
        op_type = 4'd7; bit_in = 1'b1; run_one();
        op_type = 4'd7; bit_in = 1'b0; run_one();
        // R9 no-op
        op_type = 4'd15; next_pc = 16'h1234; run_one();

        for (int i = 0; i < 600; i++) begin
            randomize_inputs();
            run_one();
            if (i % 7 == 0) begin
                op_type = 4'd7; bit_in = 1'b1;
                @(negedge clk);
                chk("R1", "idle res_vld", int'(res_vld), 0);
                chk("R1", "idle taken", int'(taken), 0);
                chk("R1", "idle bit_clr", int'(bit_clr), 0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule